// File: doc/BRIEF.md
# Address Decode and Bus Strobe Glue

This block is the combinational glue between an 8-bit microprocessor with a 16-bit address bus and its memories and peripherals. The address is split into a large RAM region in the lower half, four small I/O windows just below the half-way point, and a ROM region in the upper half. One active-low chip select is produced per target. At most one of them is asserted for any address.

Read and write strobes are qualified by the phase-2 clock, by the read/write line and by a bus-enable input. That input is low when another master owns the bus. The ROM gets its own output enable, which only opens on reads from the ROM range. A write strobe for an external ROM programmer also passes through the same qualification. The four active-low peripheral interrupt lines are merged by a logical AND into one active-low request to the CPU.

All pins are plain control signals. No data stream passes through the block, so it has no valid/ready handshake and applies no back-pressure. A parameter selects a reduced decode variant. In that variant a 64-byte window just below the I/O windows answers to no select.

Top module: `bus_glue`

## Requirements
- R1: With full decode, `ram_cs_n` is low exactly for addresses 0x0000 to 0x7FBF.
- R2: `io_cs_n[k]` is low exactly for addresses 0x7FC0 + 16*k to 0x7FCF + 16*k, for k = 0..3. Bit 0 is the lowest window.
- R3: `rom_cs_n` is low exactly when address bit 15 is 1 (0x8000 to 0xFFFF).
- R4: For every address, at most one of `ram_cs_n`, `rom_cs_n` and `io_cs_n[3:0]` is low. With full decode, exactly one is low.
- R5: With reduced decode, addresses 0x7F80 to 0x7FBF assert no select, while 0x0000 to 0x7F7F still select RAM.
- R6: `ram_oe_n` is low exactly when `phi2` = 1, `rw` = 1 (read) and `bus_en` = 1.
- R7: `ram_we_n` is low exactly when `phi2` = 1, `rw` = 0 (write) and `bus_en` = 1.
- R8: `rom_oe_n` is low exactly when the read condition of R6 holds and the address is in the ROM range. It stays high during every write.
- R9: `rom_we_n` is low exactly when the write condition of R7 holds and `rom_prog_we_n` = 0.
- R10: `cpu_irq_n` is low exactly when at least one bit of `irq_in_n` is low.
- R11: The chip selects depend only on the address. Changing `phi2`, `rw` or `bus_en` leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | 16 | CPU address bus |
| rw | input | 1 | 1 = read cycle, 0 = write cycle |
| phi2 | input | 1 | Phase-2 clock; strobes are only active while it is high |
| bus_en | input | 1 | 1 = CPU drives the bus |
| rom_prog_we_n | input | 1 | Active-low write request from a ROM programmer |
| irq_in_n | input | 4 | Active-low interrupt lines, one per I/O window |
| ram_cs_n | output | 1 | RAM chip select, active low |
| rom_cs_n | output | 1 | ROM chip select, active low |
| io_cs_n | output | 4 | I/O window selects, active low |
| ram_oe_n | output | 1 | Qualified read strobe, active low |
| ram_we_n | output | 1 | Qualified write strobe, active low |
| rom_oe_n | output | 1 | ROM output enable: reads in the ROM range only, active low |
| rom_we_n | output | 1 | Qualified ROM programming strobe, active low |
| cpu_irq_n | output | 1 | Merged interrupt request, active low |

## Verification
The bench instantiates the block twice, once with the default full decode and once with the reduced-decode parameter set. It sweeps every one of the 65536 addresses through both instances in the same cycles. This covers every window edge and shows where the reduced variant opens its unmapped hole while the other instance still maps it to RAM. Exhaustive truth tables over the strobe inputs and the interrupt lines complete the coverage.

// File: rtl/glue_pkg.sv
package glue_pkg;

  // Qualified bus strobes, active high inside the block
  typedef struct packed {
    logic rd;
    logic wr;
    logic rom_rd;
    logic rom_wr;
  } strobe_t;

  // Bytes in an address window of the given bit count
  function automatic int unsigned win_bytes(input int unsigned bits);
    return 32'd1 << bits;
  endfunction

endpackage

// File: rtl/glue_addr_decode.sv
module glue_addr_decode
  import glue_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned IO_SLOTS    = 4,
  parameter int unsigned IO_WIN_BITS = 4,
  parameter int unsigned HOLE_BYTES  = 64,
  parameter bit          REDUCED     = 1'b0
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic                ram_sel,
  output logic                rom_sel,
  output logic [IO_SLOTS-1:0] io_sel
);

  localparam int unsigned HALF      = 32'd1 << (ADDR_W - 1);
  localparam int unsigned WIN       = win_bytes(IO_WIN_BITS);
  localparam int unsigned IO_BASE   = HALF - IO_SLOTS * WIN;
  localparam int unsigned HOLE_BASE = IO_BASE - HOLE_BYTES;
  localparam int unsigned RAM_END   = REDUCED ? HOLE_BASE : IO_BASE;

  int unsigned a_u;
  assign a_u = 32'(addr);

  assign rom_sel = addr[ADDR_W-1];
  assign ram_sel = (a_u < RAM_END);

  for (genvar k = 0; k < IO_SLOTS; k++) begin : g_slot
    localparam int unsigned LO = IO_BASE + k * WIN;
    assign io_sel[k] = (a_u >= LO) && (a_u < LO + WIN);
  end

  always_comb begin
    assert_one_select_R4 : assert ($onehot0({ram_sel, rom_sel, io_sel}))
      else $error("more than one select active");
    if (!REDUCED) begin
      assert_full_cover_R1 : assert ($countones({ram_sel, rom_sel, io_sel}) == 1)
        else $error("address left unmapped in full decode");
    end
    if (REDUCED && a_u >= HOLE_BASE && a_u < IO_BASE) begin
      assert_hole_empty_R5 : assert (!ram_sel && !rom_sel && io_sel == '0)
        else $error("select active inside reduced-decode hole");
    end
  end

endmodule

// File: rtl/glue_strobe_gate.sv
module glue_strobe_gate
  import glue_pkg::*;
(
  input  logic    phi2,
  input  logic    rw,
  input  logic    bus_en,
  input  logic    rom_sel,
  input  logic    rom_prog_we_n,
  output strobe_t strb
);

  logic live;

  always_comb begin
    live        = phi2 & bus_en;
    strb.rd     = live & rw;
    strb.wr     = live & ~rw;
    strb.rom_rd = strb.rd & rom_sel;
    strb.rom_wr = strb.wr & ~rom_prog_we_n;

    assert_rd_wr_excl_R7 : assert (!(strb.rd && strb.wr))
      else $error("read and write strobes both active");
    if (!phi2 || !bus_en) begin
      assert_idle_quiet_R6 : assert (strb == '0)
        else $error("strobe active outside phase 2 or without bus ownership");
    end
    if (strb.rom_rd) begin
      assert_rom_read_only_R8 : assert (rw && rom_sel && !strb.wr)
        else $error("ROM output enabled outside a ROM read");
    end
    if (strb.rom_wr) begin
      assert_prog_gated_R9 : assert (strb.wr && !rom_prog_we_n)
        else $error("ROM write strobe without qualified write");
    end
  end

endmodule

// File: rtl/glue_irq_merge.sv
module glue_irq_merge #(
  parameter int unsigned LINES = 4
) (
  input  logic [LINES-1:0] irq_in_n,
  output logic             irq_out_n
);

  always_comb begin
    irq_out_n = &irq_in_n;
    if ($countones(irq_in_n) != LINES) begin
      assert_irq_any_R10 : assert (!irq_out_n)
        else $error("pending device interrupt not forwarded");
    end
  end

endmodule

// File: rtl/bus_glue.sv
module bus_glue
  import glue_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned IO_SLOTS    = 4,
  parameter int unsigned IO_WIN_BITS = 4,
  parameter int unsigned HOLE_BYTES  = 64,
  parameter bit          REDUCED     = 1'b0
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                rw,
  input  logic                phi2,
  input  logic                bus_en,
  input  logic                rom_prog_we_n,
  input  logic [IO_SLOTS-1:0] irq_in_n,
  output logic                ram_cs_n,
  output logic                rom_cs_n,
  output logic [IO_SLOTS-1:0] io_cs_n,
  output logic                ram_oe_n,
  output logic                ram_we_n,
  output logic                rom_oe_n,
  output logic                rom_we_n,
  output logic                cpu_irq_n
);

  logic                ram_sel;
  logic                rom_sel;
  logic [IO_SLOTS-1:0] io_sel;
  strobe_t             strb;

  glue_addr_decode #(
    .ADDR_W(ADDR_W), .IO_SLOTS(IO_SLOTS), .IO_WIN_BITS(IO_WIN_BITS),
    .HOLE_BYTES(HOLE_BYTES), .REDUCED(REDUCED)
  ) u_dec (
    .addr(addr), .ram_sel(ram_sel), .rom_sel(rom_sel), .io_sel(io_sel)
  );

  glue_strobe_gate u_gate (
    .phi2(phi2), .rw(rw), .bus_en(bus_en), .rom_sel(rom_sel),
    .rom_prog_we_n(rom_prog_we_n), .strb(strb)
  );

  glue_irq_merge #(.LINES(IO_SLOTS)) u_irq (
    .irq_in_n(irq_in_n), .irq_out_n(cpu_irq_n)
  );

  assign ram_cs_n = ~ram_sel;
  assign rom_cs_n = ~rom_sel;
  assign io_cs_n  = ~io_sel;
  assign ram_oe_n = ~strb.rd;
  assign ram_we_n = ~strb.wr;
  assign rom_oe_n = ~strb.rom_rd;
  assign rom_we_n = ~strb.rom_wr;

endmodule

// File: tb/bus_glue_bench.sv
module bus_glue_bench;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [15:0] addr = '0;
  logic rw = 1'b1, phi2 = 1'b0, bus_en = 1'b1, prog_n = 1'b1;
  logic [3:0] irq_n = 4'hF;

  logic f_ram, f_rom, f_oe, f_we, f_roe, f_rwe, f_irq;
  logic [3:0] f_io;
  logic r_ram, r_rom, r_oe, r_we, r_roe, r_rwe, r_irq;
  logic [3:0] r_io;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  bus_glue u_bus_glue (
    .addr(addr), .rw(rw), .phi2(phi2), .bus_en(bus_en), .rom_prog_we_n(prog_n),
    .irq_in_n(irq_n), .ram_cs_n(f_ram), .rom_cs_n(f_rom), .io_cs_n(f_io),
    .ram_oe_n(f_oe), .ram_we_n(f_we), .rom_oe_n(f_roe), .rom_we_n(f_rwe),
    .cpu_irq_n(f_irq)
  );

  bus_glue #(.REDUCED(1'b1)) u_bus_glue_reduced (
    .addr(addr), .rw(rw), .phi2(phi2), .bus_en(bus_en), .rom_prog_we_n(prog_n),
    .irq_in_n(irq_n), .ram_cs_n(r_ram), .rom_cs_n(r_rom), .io_cs_n(r_io),
    .ram_oe_n(r_oe), .ram_we_n(r_we), .rom_oe_n(r_roe), .rom_we_n(r_rwe),
    .cpu_irq_n(r_irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // active-low {rom, ram, io[3:0]} from the memory map
  function automatic logic [5:0] exp_sel(input int a, input bit red);
    logic [5:0] s = 6'h3F;
    if (a >= 32'h8000) s[5] = 1'b0;
    else if (a >= 32'h7FC0) s[(a - 32'h7FC0) / 16] = 1'b0;
    else if (!red || a < 32'h7F80) s[4] = 1'b0;
    return s;
  endfunction

  task automatic t_idle();
    @(posedge clk); addr = 16'h9000; rw = 1'b1; phi2 = 1'b0; bus_en = 1'b1;
    prog_n = 1'b0; irq_n = 4'hF;
    @(negedge clk);
    chk({f_oe, f_we, f_roe, f_rwe} == 4'hF, "R6 idle strobes",
        {f_oe, f_we, f_roe, f_rwe}, 4'hF);
    chk(f_irq == 1'b1, "R10 idle irq", f_irq, 1);
    prog_n = 1'b1;
  endtask

  task automatic t_sweep();
    phi2 = 1'b0;
    for (int a = 0; a < 65536; a++) begin
      @(posedge clk); addr = a[15:0];
      @(negedge clk);
      chk({f_rom, f_ram, f_io} == exp_sel(a, 1'b0), "R1 R2 R3 R4 full map",
          {f_rom, f_ram, f_io}, exp_sel(a, 1'b0));
      chk({r_rom, r_ram, r_io} == exp_sel(a, 1'b1), "R5 R4 reduced map",
          {r_rom, r_ram, r_io}, exp_sel(a, 1'b1));
    end
  endtask

  task automatic t_strobes();
    for (int m = 0; m < 32; m++) begin
      logic ph, r, be, pn, rom;
      logic [3:0] e;
      {rom, ph, r, be, pn} = m[4:0];
      @(posedge clk);
      addr = rom ? 16'hC123 : 16'h1234; phi2 = ph; rw = r; bus_en = be; prog_n = pn;
      @(negedge clk);
      e[3] = ~(ph & be & r);
      e[2] = ~(ph & be & ~r);
      e[1] = ~(ph & be & r & rom);
      e[0] = ~(ph & be & ~r & ~pn);
      chk({f_oe, f_we, f_roe, f_rwe} == e, "R6 R7 R8 R9 strobes",
          {f_oe, f_we, f_roe, f_rwe}, e);
      chk({f_rom, f_ram, f_io} == exp_sel(int'(addr), 1'b0), "R11 selects unaffected",
          {f_rom, f_ram, f_io}, exp_sel(int'(addr), 1'b0));
    end
    phi2 = 1'b0; prog_n = 1'b1; bus_en = 1'b1;
  endtask

  task automatic t_rom_write();
    @(posedge clk); addr = 16'hFFFC; rw = 1'b0; bus_en = 1'b1; phi2 = 1'b1; prog_n = 1'b1;
    @(negedge clk);
    chk(f_roe == 1'b1 && f_we == 1'b0, "R8 ROM write keeps output off",
        {f_roe, f_we}, 2'b10);
    phi2 = 1'b0;
  endtask

  task automatic t_irq();
    for (int m = 0; m < 16; m++) begin
      @(posedge clk); irq_n = m[3:0];
      @(negedge clk);
      chk(f_irq == (m == 15) && r_irq == (m == 15), "R10 irq merge",
          {f_irq, r_irq}, (m == 15) ? 2'b11 : 2'b00);
    end
    irq_n = 4'hF;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    t_idle();
    t_sweep();
    t_strobes();
    t_rom_write();
    t_irq();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule